// File: doc/BRIEF.md
# Histogram Transition-Error and Code-Width Analyzer

This block takes a finished code-density histogram of an n-bit converter and derives two static error arrays from it. The first is the total unadjusted error at every code transition. The second is the differential nonlinearity of every inner code. It also keeps the smallest and largest value of each array. The histogram sits in an external synchronous memory with one cycle of read latency. The block drives the read address and makes two passes over that memory. The first pass sums all hit counts. The second pass accumulates the counts and compares each running sum with the ideal transition position.

No divider is used. Every result is given in units of hits, scaled by 2^FRAC. One LSB of the converter equals the average number of hits per code, which is total/2^n, so a result divided by (avg × 2^FRAC) gives the error in LSB. The resolution n is chosen per run, from 2 to MAX_N. A select input picks either the uncompensated ideal curve, where every code is 1 LSB wide, or the half-LSB-compensated curve, where the first code is 0.5 LSB wide and the last is 1.5 LSB wide.

Top module: `hist_err_scan`

## Requirements
- R1: A `start` pulse seen while the block is idle latches `n_bits` and `comp_sel`. The first pass reads addresses 0 to 2^n−1 and sums their counts into the total. Addresses at 2^n and above have no effect on any result.
- R2: The unit of every result is 2^-FRAC hit. The average per code is avgf = total·2^(FRAC−n), and this value is exact.
- R3: With `comp_sel`=0, transition i reports tue = cum_i·2^FRAC − (i+1)·avgf. Here cum_i is the sum of the counts of codes 0 through i.
- R4: With `comp_sel`=1, transition i reports tue = cum_i·2^FRAC − (2i+1)·avgf/2.
- R5: The tue values come out one per cycle on `tue_valid`, with `res_idx` running 0, 1, …, 2^n−2 in consecutive cycles. Exactly 2^n−1 values are produced.
- R6: For indices 1 to 2^n−2, `dnl_valid` is high in the same cycle as `tue_valid`, and `dnl_val` = tue[i] − tue[i−1]. There are exactly 2^n−2 such values, and index 0 never carries one.
- R7: A code with zero hits gives a DNL of exactly −avgf, which is −1 LSB. No DNL is ever below −avgf, and large positive DNL values are not clipped.
- R8: When `done` rises after a successful run, `tue_min`/`tue_max` hold the extremes of the tue array and `dnl_min`/`dnl_max` hold the extremes of the dnl array, all compared as signed values.
- R9: If the total is zero, the run ends with `err` high and a `done` pulse, and no tue or dnl value is produced. `err` stays high until the next start.
- R10: After reset, `tue_valid`, `dnl_valid`, `done`, `err` and `hist_addr` are all zero.
- R11: `done` is a one-cycle pulse. After a successful run it comes in the cycle after the last `tue_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start | input | 1 | begins a run when idle |
| n_bits | input | $clog2(MAX_N+1) | converter resolution for the run, 2..MAX_N |
| comp_sel | input | 1 | 1 selects the half-LSB-compensated ideal curve |
| hist_addr | output | MAX_N | histogram read address |
| hist_rdata | input | CNT_W | hit count, returned one cycle after the address |
| tue_valid | output | 1 | tue_val and res_idx are valid |
| dnl_valid | output | 1 | dnl_val is valid for res_idx |
| res_idx | output | MAX_N | transition / code index of the results |
| tue_val | output | CNT_W+MAX_N+FRAC+1 | signed transition error |
| dnl_val | output | CNT_W+MAX_N+FRAC+1 | signed code-width error |
| tue_min | output | CNT_W+MAX_N+FRAC+1 | smallest tue of the run |
| tue_max | output | CNT_W+MAX_N+FRAC+1 | largest tue of the run |
| dnl_min | output | CNT_W+MAX_N+FRAC+1 | smallest dnl of the run |
| dnl_max | output | CNT_W+MAX_N+FRAC+1 | largest dnl of the run |
| done | output | 1 | one-cycle end-of-run pulse |
| err | output | 1 | run aborted on an empty histogram |

## Verification
The hardest cases to reach from the ports are the DNL extremes: a code with no hits at all, which must land exactly on −1 LSB, and a single code far wider than the rest. Both are reached by loading the histogram memory model with chosen patterns, including a hole and one dominant bin. The stimulus sweeps every resolution from 2 to 5, both ideal curves, and a full-width run. An empty histogram, with nonzero data placed just past its last bin, covers the abort path.

// File: rtl/hist_err_scan.sv
module hist_err_scan #(
  parameter int MAX_N = 8,
  parameter int CNT_W = 12,
  parameter int FRAC  = 10
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [$clog2(MAX_N+1)-1:0]       n_bits,
  input  logic                             comp_sel,
  output logic [MAX_N-1:0]                 hist_addr,
  input  logic [CNT_W-1:0]                 hist_rdata,
  output logic                             tue_valid,
  output logic                             dnl_valid,
  output logic [MAX_N-1:0]                 res_idx,
  output logic signed [CNT_W+MAX_N+FRAC:0] tue_val,
  output logic signed [CNT_W+MAX_N+FRAC:0] dnl_val,
  output logic signed [CNT_W+MAX_N+FRAC:0] tue_min,
  output logic signed [CNT_W+MAX_N+FRAC:0] tue_max,
  output logic signed [CNT_W+MAX_N+FRAC:0] dnl_min,
  output logic signed [CNT_W+MAX_N+FRAC:0] dnl_max,
  output logic                             done,
  output logic                             err
);
  localparam int NB_W  = $clog2(MAX_N+1);
  localparam int TOT_W = CNT_W + MAX_N;
  localparam int VAL_W = TOT_W + FRAC + 1;

  typedef enum logic [1:0] {S_IDLE, S_SUM, S_SCAN, S_FIN} st_t;
  st_t st;

  logic [NB_W-1:0]         n_q;
  logic                    comp_q;
  logic [MAX_N-1:0]        addr, ridx;
  logic                    iss, rv;
  logic [TOT_W-1:0]        total, cum;
  logic signed [VAL_W-1:0] avg, ideal, prev_tue;

  logic [MAX_N:0]          span;
  logic [MAX_N-1:0]        last, last_tr;
  logic [TOT_W-1:0]        total_nxt, cum_nxt;
  logic signed [VAL_W-1:0] avg_nxt, tue_now, dnl_now;

  assign span      = (MAX_N+1)'(1) << n_q;
  assign last      = span[MAX_N-1:0] - 1'b1;
  assign last_tr   = last - 1'b1;
  assign hist_addr = addr;
  assign total_nxt = total + TOT_W'(hist_rdata);
  assign cum_nxt   = cum + TOT_W'(hist_rdata);
  assign avg_nxt   = VAL_W'({1'b0, total_nxt, {FRAC{1'b0}}} >> n_q);
  assign tue_now   = $signed({1'b0, cum_nxt, {FRAC{1'b0}}}) - ideal;
  assign dnl_now   = tue_now - prev_tue;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      n_q <= '0; comp_q <= 1'b0;
      addr <= '0; ridx <= '0; iss <= 1'b0; rv <= 1'b0;
      total <= '0; cum <= '0;
      avg <= '0; ideal <= '0; prev_tue <= '0;
      tue_valid <= 1'b0; dnl_valid <= 1'b0; res_idx <= '0;
      tue_val <= '0; dnl_val <= '0;
      tue_min <= '0; tue_max <= '0; dnl_min <= '0; dnl_max <= '0;
      done <= 1'b0; err <= 1'b0;
    end else begin
      tue_valid <= 1'b0;
      dnl_valid <= 1'b0;
      done      <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          n_q <= n_bits; comp_q <= comp_sel;
          addr <= '0; iss <= 1'b1; rv <= 1'b0;
          total <= '0; err <= 1'b0;
          st <= S_SUM;
        end
        S_SUM: begin
          if (iss) begin
            addr <= addr + 1'b1;
            if (addr == last) iss <= 1'b0;
          end
          rv   <= iss;
          ridx <= addr;
          if (rv) begin
            total <= total_nxt;
            if (ridx == last) begin
              if (total_nxt == '0) begin
                err <= 1'b1; done <= 1'b1; st <= S_IDLE;
              end else begin
                avg   <= avg_nxt;
                ideal <= comp_q ? (avg_nxt >>> 1) : avg_nxt;
                cum   <= '0; addr <= '0; iss <= 1'b1;
                st    <= S_SCAN;
              end
            end
          end
        end
        S_SCAN: begin
          if (iss) begin
            addr <= addr + 1'b1;
            if (addr == last_tr) iss <= 1'b0;
          end
          rv   <= iss;
          ridx <= addr;
          if (rv) begin
            cum       <= cum_nxt;
            ideal     <= ideal + avg;
            prev_tue  <= tue_now;
            tue_valid <= 1'b1;
            res_idx   <= ridx;
            tue_val   <= tue_now;
            if (ridx == '0) begin
              tue_min <= tue_now; tue_max <= tue_now;
            end else begin
              if (tue_now < tue_min) tue_min <= tue_now;
              if (tue_now > tue_max) tue_max <= tue_now;
              dnl_valid <= 1'b1;
              dnl_val   <= dnl_now;
              if (ridx == MAX_N'(1)) begin
                dnl_min <= dnl_now; dnl_max <= dnl_now;
              end else begin
                if (dnl_now < dnl_min) dnl_min <= dnl_now;
                if (dnl_now > dnl_max) dnl_max <= dnl_now;
              end
            end
            if (ridx == last_tr) st <= S_FIN;
          end
        end
        default: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
      endcase
    end
  end

  AST_DNL_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    dnl_valid |-> dnl_val >= -avg); // R7
  AST_DNL_WITH_TUE: assert property (@(posedge clk) disable iff (!rst_n)
    dnl_valid |-> (tue_valid && res_idx != '0)); // R6
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tue_valid && $past(tue_valid)) |-> res_idx == $past(res_idx) + 1'b1); // R5
  AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !tue_valid && !dnl_valid); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_LIMIT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (tue_min <= tue_max && dnl_min <= dnl_max)); // R8
endmodule

// File: tb/hist_err_scan_test.sv
`timescale 1ns/1ps
module hist_err_scan_test;
  localparam int MAX_N = 8, CNT_W = 12, FRAC = 10;
  localparam int VAL_W = CNT_W + MAX_N + FRAC + 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, comp_sel = 1'b0;
  logic [3:0] n_bits = 4'd2;
  logic [MAX_N-1:0] hist_addr, res_idx;
  logic [CNT_W-1:0] hist_rdata = '0;
  logic tue_valid, dnl_valid, done, err;
  logic signed [VAL_W-1:0] tue_val, dnl_val, tue_min, tue_max, dnl_min, dnl_max;

  hist_err_scan #(.MAX_N(MAX_N), .CNT_W(CNT_W), .FRAC(FRAC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .n_bits(n_bits), .comp_sel(comp_sel),
    .hist_addr(hist_addr), .hist_rdata(hist_rdata),
    .tue_valid(tue_valid), .dnl_valid(dnl_valid), .res_idx(res_idx),
    .tue_val(tue_val), .dnl_val(dnl_val), .tue_min(tue_min), .tue_max(tue_max),
    .dnl_min(dnl_min), .dnl_max(dnl_max), .done(done), .err(err));

  always #4 clk = ~clk;

  logic [CNT_W-1:0] mem [256];
  always @(posedge clk) hist_rdata <= mem[hist_addr];

  int checks = 0, fails = 0, cyc = 0;
  longint got_tue [256], got_dnl [256];
  int tcyc [256];
  int ntue, ndnl, done_cyc, dnl_at0, err_valid;
  bit done_seen;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (tue_valid) begin
      got_tue[res_idx] = longint'(tue_val); tcyc[res_idx] = cyc; ntue++;
      if (err) err_valid++;
    end
    if (dnl_valid) begin
      got_dnl[res_idx] = longint'(dnl_val); ndnl++;
      if (res_idx == 0) dnl_at0++;
    end
    if (done) begin done_seen = 1'b1; done_cyc = cyc; end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(input int p);
    for (int i = 0; i < 256; i++) begin
      case (p)
        0: mem[i] = 12'd5;
        1: mem[i] = CNT_W'(i + 1);
        2: mem[i] = (i == 2) ? 12'd0 : 12'd7;
        3: mem[i] = CNT_W'($urandom % 400);
        default: mem[i] = (i == 1) ? 12'd900 : 12'd3;
      endcase
    end
  endtask

  task automatic run(input int n, input bit comp, input int p);
    int w;
    longint total, avgf, cum, ideal, e, prev, tmin, tmax, dmin, dmax, d;
    fill(p);
    ntue = 0; ndnl = 0; dnl_at0 = 0; err_valid = 0; done_seen = 1'b0;
    @(negedge clk);
    n_bits = 4'(n); comp_sel = comp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (!done_seen && w < 5000) begin @(negedge clk); w++; end
    if (!done_seen) begin chk(0, "R11 watchdog", w, 0); return; end
    total = 0;
    for (int i = 0; i < (1 << n); i++) total += longint'(mem[i]);
    avgf = total << (FRAC - n);
    chk(ntue == (1 << n) - 1, "R5 tue count", ntue, (1 << n) - 1);
    chk(ndnl == (1 << n) - 2, "R6 dnl count", ndnl, (1 << n) - 2);
    chk(dnl_at0 == 0, "R6 no dnl at index 0", dnl_at0, 0);
    chk(!err, "R9 err clear", err, 0);
    chk(done_cyc == tcyc[(1 << n) - 2] + 1, "R11 done timing", done_cyc, tcyc[(1 << n) - 2] + 1);
    cum = 0; prev = 0; tmin = 0; tmax = 0; dmin = 0; dmax = 0;
    for (int i = 0; i <= (1 << n) - 2; i++) begin
      cum += longint'(mem[i]);
      ideal = comp ? ((2 * i + 1) * avgf) / 2 : (i + 1) * avgf;
      e = (cum << FRAC) - ideal;
      chk(got_tue[i] == e, comp ? "R4 tue compensated" : "R3 tue uncompensated", got_tue[i], e);
      chk(tcyc[i] == tcyc[0] + i, "R5 one per cycle", tcyc[i], tcyc[0] + i);
      if (i == 0) begin tmin = e; tmax = e; end
      else begin
        if (e < tmin) tmin = e;
        if (e > tmax) tmax = e;
        d = e - prev;
        chk(got_dnl[i] == d, "R6 dnl value", got_dnl[i], d);
        if (i == 1) begin dmin = d; dmax = d; end
        else begin
          if (d < dmin) dmin = d;
          if (d > dmax) dmax = d;
        end
      end
      prev = e;
    end
    chk(tue_min == tmin && tue_max == tmax, "R8 tue limits", tue_min, tmin);
    chk(dnl_min == dmin && dnl_max == dmax, "R8 dnl limits", dnl_max, dmax);
    if (p == 2) chk(got_dnl[2] == -avgf, "R7 missing code is -1 LSB", got_dnl[2], -avgf);
    if (p == 4) chk(got_dnl[1] == (longint'(900) << FRAC) - avgf, "R7 wide code unclipped",
                    got_dnl[1], (longint'(900) << FRAC) - avgf);
    if (p == 0) chk(got_tue[0] == (comp ? (avgf / 2) : 0), "R2 uniform average exact",
                    got_tue[0], comp ? (avgf / 2) : 0);
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL R11 global watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!tue_valid && !dnl_valid && !done && !err, "R10 reset outputs", {tue_valid, dnl_valid, done, err}, 0);
    chk(hist_addr == 0, "R10 reset address", hist_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int n = 2; n <= 5; n++)
      for (int c = 0; c < 2; c++)
        for (int p = 0; p < 5; p++) run(n, c[0], p);
    run(8, 1'b0, 3);
    run(8, 1'b1, 1);
    // R1: bins beyond 2^n ignored; R9: empty histogram aborts
    for (int i = 0; i < 256; i++) mem[i] = (i < 8) ? 12'd0 : 12'd9;
    ntue = 0; ndnl = 0; done_seen = 1'b0;
    @(negedge clk);
    n_bits = 4'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int w = 0; w < 200 && !done_seen; w++) @(negedge clk);
    chk(done_seen, "R9 abort done", done_seen, 1);
    chk(err, "R9 err set", err, 1);
    chk(ntue == 0 && ndnl == 0, "R1 R9 no outputs", ntue + ndnl, 0);
    @(negedge clk);
    chk(err, "R9 err held", err, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule